// File: doc/BRIEF.md
# Interleave and Bit-Position Timing Controller

This block is the global timing source for a bit-serial arithmetic processor that time-shares one datapath among a fixed number of interleaved slots. Three chained counters track the active slot (fastest), the bit position inside a double-length word (advanced once per full sweep of the slots), and the block-set index (advanced once per complete block period). From these counts the block derives, for every cycle, whether the current slot is loading operands or operating on them, which task group owns the slot, which arithmetic mode the processor must use, and the strobes that mark block and data-set boundaries and the start of each task.

Fixed slot ranges carry fixed work. The lowest five slots form covariance products over consecutive block sets. One slot runs the sequential solve steps (factorisation, elimination, substitution, variance), alternating subtract-product and divide modes. Four slots compute transform matrix-vector products. The remaining slots sit idle with zeroed operands. When the last block set of a data set ends, the solve slot starts on the finished covariance data while the product slots begin the next data set in the same cycle.

Top module: `tctl_timing`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls with `en_i` low, the counters read 0, `load_o` is 1, `task_o` is 0, `mode_o` is 0, `start_o` is 1 and `zero_op_o` is 0.
- R2: On every clock edge with `en_i` high, `slot_o` advances by one and returns to 0 after 12.
- R3: `bit_o` advances by one only on an enabled edge where `slot_o` is 12, and returns to 0 after 23.
- R4: `word_o` advances only on an enabled edge where `slot_o` is 12 and `bit_o` is 23; on such an edge it returns to 0 when it is at or above `n_sets_i`, so it spans 0 to N.
- R5: On an edge with `en_i` low, every output keeps its value.
- R6: `load_o` is 1 while `bit_o` is 0 to 11 (the first 156 cycles of each 312-cycle block period) and 0 while `bit_o` is 12 to 23.
- R7: `task_o` is 0 (covariance) for slots 0 to 4, 1 (solve) for slot 5, 2 (transform) for slots 6 to 9 and 3 (idle) for slots 10 to 12.
- R8: `mode_o` has bit 1 = divide and bit 0 = subtract; it is 2'b00 for covariance, transform and idle slots, and for slot 5 it is 2'b01 when `word_o` is even and 2'b10 when odd.
- R9: `zero_op_o` is 1 exactly on idle slots (10 to 12).
- R10: `blk_end_o` is 1 exactly when `slot_o` is 12 and `bit_o` is 23.
- R11: `set_end_o` is 1 exactly when `blk_end_o` is 1 and `word_o` is at or above `n_sets_i`.
- R12: `start_o` is 1 only when `bit_o` is 0: in every block period for slot 5, and for slots 0 to 9 only when `word_o` is 0; never on idle slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance enable for the counter chain |
| n_sets_i | input | 8 | Last block-set index N |
| slot_o | output | 4 | Current interleave slot |
| bit_o | output | 5 | Current bit position in the double-length word |
| word_o | output | 8 | Current block-set index |
| load_o | output | 1 | 1 = load phase, 0 = operate phase |
| task_o | output | 2 | Task group owning the current slot |
| mode_o | output | 2 | Processor mode: bit 1 divide, bit 0 subtract |
| zero_op_o | output | 1 | Force zero operands on idle slots |
| start_o | output | 1 | A new task begins on this slot |
| blk_end_o | output | 1 | Last cycle of a block period |
| set_end_o | output | 1 | Last cycle of block set N |

## Verification
A wrong slot count shows within one cycle as a wrong task, mode or idle flag, because every decoded output follows the slot. A slip in the bit counter surfaces at the next slot wrap as a load/operate edge 13 cycles early or late and a misplaced block-end strobe. A faulty block-set counter only appears at a block boundary: the solve slot's mode parity flips in the wrong block, or the set-end and start strobes land one block period (312 cycles) away from where they belong, so runs span several full data sets with different N and with stalls.

// File: rtl/tctl_pkg.sv
`timescale 1ns/1ps
package tctl_pkg;

  typedef enum logic [1:0] {
    TASK_COV   = 2'd0,
    TASK_SOLVE = 2'd1,
    TASK_DFT   = 2'd2,
    TASK_IDLE  = 2'd3
  } task_e;

  typedef struct packed {
    logic       load;
    task_e      tsk;
    logic [1:0] mode;
    logic       zero_op;
    logic       start;
    logic       blk_end;
    logic       set_end;
  } ctl_t;

endpackage

// File: rtl/tctl_wrap_cnt.sv
`timescale 1ns/1ps
// Modulo counter with a runtime limit; reports the wrap and its next value.
module tctl_wrap_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic         wrap
);

  always_comb begin
    wrap = step && (q >= limit);
    nxt  = q;
    if (step) nxt = wrap ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/tctl_decode.sv
`timescale 1ns/1ps
// Registered decode of the next counter state, so outputs line up with counts.
module tctl_decode
  import tctl_pkg::*;
#(
  parameter int SLOTS      = 13,
  parameter int BITS       = 24,
  parameter int WORD_W     = 8,
  parameter int COV_LAST   = 4,
  parameter int SOLVE_SLOT = 5,
  parameter int DFT_LAST   = 9,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int BIT_W      = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic [BIT_W-1:0]  bit_nxt,
  input  logic [WORD_W-1:0] word_nxt,
  input  logic [WORD_W-1:0] n_sets,
  output ctl_t              ctl_q
);

  localparam int HALF = BITS / 2;

  function automatic ctl_t dec(input logic [SLOT_W-1:0] s,
                               input logic [BIT_W-1:0]  b,
                               input logic [WORD_W-1:0] w,
                               input logic [WORD_W-1:0] n);
    ctl_t c;
    c = '0;
    c.load = (b < BIT_W'(HALF));
    if (s <= SLOT_W'(COV_LAST))        c.tsk = TASK_COV;
    else if (s == SLOT_W'(SOLVE_SLOT)) c.tsk = TASK_SOLVE;
    else if (s <= SLOT_W'(DFT_LAST))   c.tsk = TASK_DFT;
    else                               c.tsk = TASK_IDLE;
    if (c.tsk == TASK_SOLVE) c.mode = w[0] ? 2'b10 : 2'b01;
    c.zero_op = (c.tsk == TASK_IDLE);
    c.blk_end = (s == SLOT_W'(SLOTS - 1)) && (b == BIT_W'(BITS - 1));
    c.set_end = c.blk_end && (w >= n);
    c.start   = (b == '0) &&
                ((c.tsk == TASK_SOLVE) || ((c.tsk != TASK_IDLE) && (w == '0)));
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= dec('0, '0, '0, n_sets);
    else     ctl_q <= dec(slot_nxt, bit_nxt, word_nxt, n_sets);
  end

endmodule

// File: rtl/tctl_timing.sv
`timescale 1ns/1ps
module tctl_timing
  import tctl_pkg::*;
#(
  parameter int SLOTS      = 13,
  parameter int BITS       = 24,
  parameter int WORD_W     = 8,
  parameter int COV_LAST   = 4,
  parameter int SOLVE_SLOT = 5,
  parameter int DFT_LAST   = 9
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic [WORD_W-1:0]          n_sets_i,
  output logic [$clog2(SLOTS)-1:0]   slot_o,
  output logic [$clog2(BITS)-1:0]    bit_o,
  output logic [WORD_W-1:0]          word_o,
  output logic                       load_o,
  output logic [1:0]                 task_o,
  output logic [1:0]                 mode_o,
  output logic                       zero_op_o,
  output logic                       start_o,
  output logic                       blk_end_o,
  output logic                       set_end_o
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BITS);
  localparam int HALF   = BITS / 2;

  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic [BIT_W-1:0]  bit_q, bit_nxt;
  logic [WORD_W-1:0] word_q, word_nxt;
  logic              slot_wrap, bit_wrap, word_wrap;
  ctl_t              ctl;

  tctl_wrap_cnt #(.W(SLOT_W)) slot_cnt_i (
    .clk(clk), .rst(rst), .step(en_i), .limit(SLOT_W'(SLOTS - 1)),
    .q(slot_q), .nxt(slot_nxt), .wrap(slot_wrap)
  );

  tctl_wrap_cnt #(.W(BIT_W)) bit_cnt_i (
    .clk(clk), .rst(rst), .step(slot_wrap), .limit(BIT_W'(BITS - 1)),
    .q(bit_q), .nxt(bit_nxt), .wrap(bit_wrap)
  );

  tctl_wrap_cnt #(.W(WORD_W)) word_cnt_i (
    .clk(clk), .rst(rst), .step(bit_wrap), .limit(n_sets_i),
    .q(word_q), .nxt(word_nxt), .wrap(word_wrap)
  );

  tctl_decode #(
    .SLOTS(SLOTS), .BITS(BITS), .WORD_W(WORD_W), .COV_LAST(COV_LAST),
    .SOLVE_SLOT(SOLVE_SLOT), .DFT_LAST(DFT_LAST)
  ) decode_i (
    .clk(clk), .rst(rst), .slot_nxt(slot_nxt), .bit_nxt(bit_nxt),
    .word_nxt(word_nxt), .n_sets(n_sets_i), .ctl_q(ctl)
  );

  assign slot_o    = slot_q;
  assign bit_o     = bit_q;
  assign word_o    = word_q;
  assign load_o    = ctl.load;
  assign task_o    = ctl.tsk;
  assign mode_o    = ctl.mode;
  assign zero_op_o = ctl.zero_op;
  assign start_o   = ctl.start;
  assign blk_end_o = ctl.blk_end;
  assign set_end_o = ctl.set_end;

  // Slot sweep: one step per enabled edge.
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    en_i |=> slot_o == (($past(slot_o) == SLOT_W'(SLOTS - 1)) ? '0 : $past(slot_o) + 1'b1));

  // Bit position holds until the slot sweep completes.
  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (en_i && slot_o != SLOT_W'(SLOTS - 1)) |=> $stable(bit_o));

  // Stall freezes counts and strobes.
  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(slot_o) && $stable(bit_o) && $stable(word_o) &&
               $stable(start_o) && $stable(mode_o)));

  // Load/operate phase follows the registered bit count.
  assert_load_phase_R6: assert property (@(posedge clk) disable iff (rst)
    load_o == (bit_o < BIT_W'(HALF)));

  // Idle slots carry a benign mode.
  assert_idle_mode_R9: assert property (@(posedge clk) disable iff (rst)
    zero_op_o |-> (mode_o == 2'b00 && task_o == 2'd3));

  // Block end is followed by the start of a new block.
  assert_blk_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (blk_end_o && en_i) |=> (slot_o == '0 && bit_o == '0));

  // Set end is followed by block set 0.
  assert_set_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (set_end_o && en_i) |=> word_o == '0);

  // Task starts only at bit position 0.
  assert_start_bit0_R12: assert property (@(posedge clk) disable iff (rst)
    start_o |-> bit_o == '0);

endmodule

// File: tb/tctl_timing_tb.sv
`timescale 1ns/1ps
module tctl_timing_tb_top;

  typedef struct {
    int  slot, bitp, word, load, tsk, mode, zop, start, blk, sete;
    bit  stall, rst_item;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] n_sets = 8'd2;
  logic [3:0] slot;
  logic [4:0] bitp;
  logic [7:0] word;
  logic       load, zop, start, blk, sete;
  logic [1:0] tsk, mode;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t q[$];
  int   ms = 0, mb = 0, mw = 0;

  always #4 clk = ~clk;

  tctl_timing dut_i (
    .clk(clk), .rst(rst), .en_i(en), .n_sets_i(n_sets),
    .slot_o(slot), .bit_o(bitp), .word_o(word), .load_o(load),
    .task_o(tsk), .mode_o(mode), .zero_op_o(zop), .start_o(start),
    .blk_end_o(blk), .set_end_o(sete)
  );

  function automatic exp_t expect_of(int s, int b, int w, int n);
    exp_t e;
    e.slot = s; e.bitp = b; e.word = w;
    e.load = (b <= 11) ? 1 : 0;                          // R6
    if (s < 5) e.tsk = 0; else if (s == 5) e.tsk = 1;    // R7
    else if (s < 10) e.tsk = 2; else e.tsk = 3;
    e.mode = (s == 5) ? ((w % 2 == 1) ? 2 : 1) : 0;      // R8
    e.zop  = (s >= 10) ? 1 : 0;                          // R9
    e.blk  = (s == 12 && b == 23) ? 1 : 0;               // R10
    e.sete = (e.blk == 1 && w >= n) ? 1 : 0;             // R11
    e.start = 0;                                         // R12
    if (b == 0 && (s == 5 || (s < 10 && w == 0))) e.start = 1;
    e.stall = 1'b0; e.rst_item = 1'b0;
    return e;
  endfunction

  task automatic chk(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: sets enable, advances the model, queues the state after the edge.
  task automatic drive(bit en_v);
    exp_t e;
    @(negedge clk);
    en = en_v;
    if (en_v) begin
      if (ms == 12) begin
        ms = 0;
        if (mb == 23) begin
          mb = 0;
          mw = (mw >= int'(n_sets)) ? 0 : mw + 1;
        end else mb++;
      end else ms++;
    end
    e = expect_of(ms, mb, mw, int'(n_sets));
    e.stall = !en_v;
    q.push_back(e);
  endtask

  // Monitor: compares after each edge, away from it.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (e.rst_item) begin
        chk("R1", int'(slot),  0, "slot");
        chk("R1", int'(bitp),  0, "bit");
        chk("R1", int'(word),  0, "word");
        chk("R1", int'(load),  1, "load");
        chk("R1", int'(tsk),   0, "task");
        chk("R1", int'(mode),  0, "mode");
        chk("R1", int'(start), 1, "start");
        chk("R1", int'(zop),   0, "zero_op");
      end else begin
        chk(e.stall ? "R5" : "R2",  int'(slot),  e.slot,  "slot");
        chk(e.stall ? "R5" : "R3",  int'(bitp),  e.bitp,  "bit");
        chk(e.stall ? "R5" : "R4",  int'(word),  e.word,  "word");
        chk(e.stall ? "R5" : "R6",  int'(load),  e.load,  "load");
        chk(e.stall ? "R5" : "R7",  int'(tsk),   e.tsk,   "task");
        chk(e.stall ? "R5" : "R8",  int'(mode),  e.mode,  "mode");
        chk(e.stall ? "R5" : "R9",  int'(zop),   e.zop,   "zero_op");
        chk(e.stall ? "R5" : "R10", int'(blk),   e.blk,   "blk_end");
        chk(e.stall ? "R5" : "R11", int'(sete),  e.sete,  "set_end");
        chk(e.stall ? "R5" : "R12", int'(start), e.start, "start");
      end
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    e = expect_of(0, 0, 0, int'(n_sets));
    e.rst_item = 1'b1;
    q.push_back(e);
    // N = 2: three block sets per data set, with occasional stalls.
    for (int i = 0; i < 3000; i++) drive((i % 97) != 40);
    // N = 0: every block ends a set.
    n_sets = 8'd0;
    for (int i = 0; i < 800; i++) drive((i % 53) != 7);
    // N = 1 with longer stall bursts.
    n_sets = 8'd1;
    for (int i = 0; i < 1400; i++) drive(!((i % 211) >= 100 && (i % 211) < 104));
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule